// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master Register File

This block holds the host-visible control registers for the bus-master DMA region of a two-channel IDE controller. The host reaches it over a byte-addressed register bus that covers a 16-byte window. Each channel owns one 8-byte slice of that window. A slice holds a command byte, a view of a mode/interrupt byte that both channels share, a status byte, a timing byte and a 32-bit descriptor-table pointer.

The DMA engines sit outside this block. They report run, halt, error and interrupt events to it as one-cycle strobes. In return, the block sends each engine one-cycle start and cancel pulses that it decodes from command writes. The shared mode byte samples the raw interrupt request of each channel. Two host-writable block bits mask those requests, and the unmasked requests are merged into one level-sensitive interrupt output.

The request side uses valid/ready. `req_ready` is held high, so a request is accepted in every cycle in which `req_valid` is high, and it is never back-pressured. Read data comes back in the cycle after acceptance, marked by `rsp_valid`. The response has no ready signal, so the requester must always be able to take it.

Top module: `idebm_regfile`

## Requirements
- R1: While reset is low, every register is cleared, `cancel_o` is high for both channels and `start_o` is low. `cancel_o` returns low after the first clock edge with reset high. A read of any mapped byte after reset returns 0x00.
- R2: Channel 0 owns window offsets 0 to 7 and channel 1 owns offsets 8 to 15. Within a slice, byte 0 is command, byte 1 is mode, byte 2 is status, byte 3 is timing and bytes 4 to 7 are the descriptor pointer, least significant byte first.
- R3: The mode byte is shared, so offsets 1 and 9 read the same value. A write to either offset changes only bits 5:4, which are the block bits for channel 0 and channel 1. The other mode bits ignore host data, and bits 7:6 and 1:0 read 0.
- R4: Mode bit 2 takes the value of `irq_req[0]`, and mode bit 3 takes the value of `irq_req[1]`, at every clock edge.
- R5: `irq_o` = (mode[2] and not mode[4]) or (mode[3] and not mode[5]). It follows the mode register with no further register stage.
- R6: On a status write, bits 6:5 take the written value. Bits 2:1 are cleared where the data bit is 1 and kept where it is 0. Bit 0 (active) is unaffected. Bits 7, 4 and 3 read 0.
- R7: `evt_run` sets status bit 0 and `evt_halt` clears it; if both strobes arrive together, the set wins. `evt_err` sets bit 1 and `evt_irq` sets bit 2. A set strobe wins over a clearing write in the same cycle.
- R8: The command byte keeps bit 0 (start) and bit 3 (direction); its other bits read 0. In the cycle after a command write, `start_o` of that channel is high for one cycle if data bit 0 is 1. If data bit 0 is 0, `cancel_o` of that channel is high for one cycle instead.
- R9: Each channel has its own timing byte at slice offset 3. It stores all 8 written bits and is independent of the other channel.
- R10: The descriptor pointer takes byte (`req_size`=0), half-word (1) and word (2 or 3) accesses. Lane k of `req_wdata` and `rsp_rdata` maps to byte `req_addr`+k.
- R11: A read accepted at a clock edge gives `rsp_valid` high for the next cycle only. Lanes that fall past offset 15 read 0xFF, and writes to them are dropped. Lanes above the access size read 0x00.
- R12: `start_o` and `cancel_o` of one channel are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset within the window |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, lane 0 in bits 7:0 |
| irq_req | input | 2 | Raw interrupt request per channel |
| evt_run | input | 2 | Engine started strobe per channel |
| evt_halt | input | 2 | Engine stopped or done strobe per channel |
| evt_err | input | 2 | Engine error strobe per channel |
| evt_irq | input | 2 | Engine interrupt strobe per channel |
| start_o | output | 2 | One-cycle start pulse per channel |
| cancel_o | output | 2 | One-cycle cancel pulse per channel |
| irq_o | output | 1 | Merged level interrupt |

## Verification
The interrupt merge is exercised with each single raw request, with both requests, and with every block-bit combination. This shows whether each mask acts on its own channel only and whether the output is an OR of the two channels. The status byte gets mixed write patterns and same-cycle event and write collisions. These separate the write-one-to-clear, plain and read-only bits and confirm which side wins a collision. The descriptor pointer is written and read at byte, half-word and word sizes and across the end of the window. This exposes lane-ordering errors, wrong access widths and writes that leak into the other channel.

// File: rtl/idebm_pkg.sv
package idebm_pkg;
  localparam int CH_NUM      = 2;
  localparam int SLICE_BYTES = 8;
  localparam int WIN_BYTES   = CH_NUM * SLICE_BYTES;
  localparam int ADDR_W      = $clog2(WIN_BYTES);
  localparam int BUS_BYTES   = 4;
  localparam int BUS_W       = BUS_BYTES * 8;
  localparam int DESC_BYTES  = 4;

  // slice layout
  localparam int OFS_CMD  = 0;
  localparam int OFS_MODE = 1;
  localparam int OFS_STAT = 2;
  localparam int OFS_TIM  = 3;
  localparam int OFS_DESC = 4;

  // bit positions
  localparam int CMD_RUN      = 0;
  localparam int CMD_DIR      = 3;
  localparam int ST_ACT       = 0;
  localparam int ST_ERR       = 1;
  localparam int ST_INT       = 2;
  localparam int ST_CTL_LSB   = 5;
  localparam int MODE_LAT_LSB = 2;
  localparam int MODE_BLK_LSB = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/idebm_bus_if.sv
module idebm_bus_if
  import idebm_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [1:0]                      req_size,
  input  logic [BUS_W-1:0]                req_wdata,
  input  logic [WIN_BYTES-1:0][7:0]       rd_bytes,
  output logic [WIN_BYTES-1:0]            wr_en,
  output logic [WIN_BYTES-1:0][7:0]       wr_data,
  output logic                            rsp_valid,
  output logic [BUS_W-1:0]                rsp_rdata
);
  logic [BUS_BYTES-1:0][7:0] rd_lane;
  logic [ADDR_W:0]           tgt;
  int                        lanes;

  assign req_ready = 1'b1;

  always_comb begin
    case (acc_size_e'(req_size))
      SZ_BYTE: lanes = 1;
      SZ_HALF: lanes = 2;
      default: lanes = BUS_BYTES;
    endcase
  end

  always_comb begin
    wr_en   = '0;
    wr_data = '0;
    rd_lane = '0;
    tgt     = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      tgt = {1'b0, req_addr} + (ADDR_W+1)'(i);
      if (i < lanes) begin
        if (tgt < (ADDR_W+1)'(WIN_BYTES)) begin
          rd_lane[i] = rd_bytes[tgt[ADDR_W-1:0]];
          if (req_valid && req_write) begin
            wr_en[tgt[ADDR_W-1:0]]   = 1'b1;
            wr_data[tgt[ADDR_W-1:0]] = req_wdata[i*8 +: 8];
          end
        end else begin
          rd_lane[i] = 8'hFF;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_lane;
    end
  end
endmodule

// File: rtl/idebm_mode.sv
module idebm_mode
  import idebm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_NUM-1:0] irq_req,
  input  logic              blk_we,
  input  logic [CH_NUM-1:0] blk_d,
  output logic [7:0]        mode_q,
  output logic              irq_o
);
  logic [CH_NUM-1:0] lat_q;
  logic [CH_NUM-1:0] blk_q;
  logic [CH_NUM-1:0] live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
      blk_q <= '0;
    end else begin
      lat_q <= irq_req;
      if (blk_we) blk_q <= blk_d;
    end
  end

  for (genvar c = 0; c < CH_NUM; c++) begin : g_live
    assign live[c] = lat_q[c] && !blk_q[c];
  end

  always_comb begin
    mode_q = '0;
    mode_q[MODE_LAT_LSB +: CH_NUM] = lat_q;
    mode_q[MODE_BLK_LSB +: CH_NUM] = blk_q;
  end

  assign irq_o = |live;
endmodule

// File: rtl/idebm_channel.sv
module idebm_channel
  import idebm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_we,
  input  logic [7:0]                 cmd_d,
  input  logic                       st_we,
  input  logic [7:0]                 st_d,
  input  logic                       tim_we,
  input  logic [7:0]                 tim_d,
  input  logic [DESC_BYTES-1:0]      desc_we,
  input  logic [DESC_BYTES-1:0][7:0] desc_d,
  input  logic                       evt_run,
  input  logic                       evt_halt,
  input  logic                       evt_err,
  input  logic                       evt_irq,
  output logic [7:0]                 cmd_q,
  output logic [7:0]                 stat_q,
  output logic [7:0]                 tim_q,
  output logic [DESC_BYTES-1:0][7:0] desc_q,
  output logic                       start_p,
  output logic                       cancel_p
);
  logic       run_q, dir_q;
  logic       act_q, err_q, int_q;
  logic [1:0] ctl_q;

  // command byte and engine pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      dir_q    <= 1'b0;
      start_p  <= 1'b0;
      cancel_p <= 1'b0;
    end else begin
      start_p  <= cmd_we && cmd_d[CMD_RUN];
      cancel_p <= cmd_we && !cmd_d[CMD_RUN];
      if (cmd_we) begin
        run_q <= cmd_d[CMD_RUN];
        dir_q <= cmd_d[CMD_DIR];
      end
    end
  end

  // status byte: engine sets take priority over host clears
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
      ctl_q <= '0;
    end else begin
      if (evt_run)       act_q <= 1'b1;
      else if (evt_halt) act_q <= 1'b0;

      if (evt_err)                   err_q <= 1'b1;
      else if (st_we && st_d[ST_ERR]) err_q <= 1'b0;

      if (evt_irq)                   int_q <= 1'b1;
      else if (st_we && st_d[ST_INT]) int_q <= 1'b0;

      if (st_we) ctl_q <= st_d[ST_CTL_LSB +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tim_q <= '0;
    else if (tim_we) tim_q <= tim_d;
  end

  for (genvar b = 0; b < DESC_BYTES; b++) begin : g_desc
    always_ff @(posedge clk) begin
      if (!rst_n) desc_q[b] <= '0;
      else if (desc_we[b]) desc_q[b] <= desc_d[b];
    end
  end

  always_comb begin
    cmd_q = '0;
    cmd_q[CMD_RUN] = run_q;
    cmd_q[CMD_DIR] = dir_q;
    stat_q = '0;
    stat_q[ST_ACT] = act_q;
    stat_q[ST_ERR] = err_q;
    stat_q[ST_INT] = int_q;
    stat_q[ST_CTL_LSB +: 2] = ctl_q;
  end
endmodule

// File: rtl/idebm_regfile.sv
module idebm_regfile
  import idebm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [3:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [1:0]        irq_req,
  input  logic [1:0]        evt_run,
  input  logic [1:0]        evt_halt,
  input  logic [1:0]        evt_err,
  input  logic [1:0]        evt_irq,
  output logic [1:0]        start_o,
  output logic [1:0]        cancel_o,
  output logic              irq_o
);
  logic [WIN_BYTES-1:0]              wr_en;
  logic [WIN_BYTES-1:0][7:0]         wr_data;
  logic [WIN_BYTES-1:0][7:0]         rd_all;
  logic [7:0]                        mode_q;
  logic [CH_NUM-1:0][7:0]            ch_cmd;
  logic [CH_NUM-1:0][7:0]            stat_q;
  logic [CH_NUM-1:0][7:0]            ch_tim;
  logic [CH_NUM-1:0][DESC_BYTES-1:0][7:0] ch_desc;
  logic [CH_NUM-1:0]                 cmd_cancel;
  logic                              rst_cancel_q;
  logic                              blk_we;
  logic [CH_NUM-1:0]                 blk_d;

  idebm_bus_if u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rd_bytes  (rd_all),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // mode byte is reachable from every slice; accesses never span two slices' mode bytes
  always_comb begin
    blk_we = 1'b0;
    blk_d  = '0;
    for (int c = 0; c < CH_NUM; c++) begin
      if (wr_en[c*SLICE_BYTES + OFS_MODE]) begin
        blk_we = 1'b1;
        blk_d  = wr_data[c*SLICE_BYTES + OFS_MODE][MODE_BLK_LSB +: CH_NUM];
      end
    end
  end

  idebm_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .blk_we  (blk_we),
    .blk_d   (blk_d),
    .mode_q  (mode_q),
    .irq_o   (irq_o)
  );

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    localparam int B = c * SLICE_BYTES;
    idebm_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (wr_en[B + OFS_CMD]),
      .cmd_d    (wr_data[B + OFS_CMD]),
      .st_we    (wr_en[B + OFS_STAT]),
      .st_d     (wr_data[B + OFS_STAT]),
      .tim_we   (wr_en[B + OFS_TIM]),
      .tim_d    (wr_data[B + OFS_TIM]),
      .desc_we  (wr_en[B + OFS_DESC +: DESC_BYTES]),
      .desc_d   (wr_data[B + OFS_DESC +: DESC_BYTES]),
      .evt_run  (evt_run[c]),
      .evt_halt (evt_halt[c]),
      .evt_err  (evt_err[c]),
      .evt_irq  (evt_irq[c]),
      .cmd_q    (ch_cmd[c]),
      .stat_q   (stat_q[c]),
      .tim_q    (ch_tim[c]),
      .desc_q   (ch_desc[c]),
      .start_p  (start_o[c]),
      .cancel_p (cmd_cancel[c])
    );
  end

  always_comb begin
    rd_all = '0;
    for (int c = 0; c < CH_NUM; c++) begin
      rd_all[c*SLICE_BYTES + OFS_CMD]  = ch_cmd[c];
      rd_all[c*SLICE_BYTES + OFS_MODE] = mode_q;
      rd_all[c*SLICE_BYTES + OFS_STAT] = stat_q[c];
      rd_all[c*SLICE_BYTES + OFS_TIM]  = ch_tim[c];
      for (int b = 0; b < DESC_BYTES; b++)
        rd_all[c*SLICE_BYTES + OFS_DESC + b] = ch_desc[c][b];
    end
  end

  // cancel both engines while in reset and up to the first active edge
  always_ff @(posedge clk) begin
    if (!rst_n) rst_cancel_q <= 1'b1;
    else        rst_cancel_q <= 1'b0;
  end

  assign cancel_o = cmd_cancel | {CH_NUM{rst_cancel_q}};
endmodule

// File: rtl/idebm_regfile_chk.sv
module idebm_regfile_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [1:0]      irq_req,
  input logic            irq_o,
  input logic [1:0]      blk,
  input logic [1:0]      start_o,
  input logic [1:0]      cancel_o,
  input logic [1:0]      evt_run,
  input logic [1:0]      evt_halt,
  input logic [1:0][7:0] stat
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r5_irq_merge: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> irq_o == (($past(irq_req[0]) && !blk[0]) || ($past(irq_req[1]) && !blk[1])));

  a_r11_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  a_r11_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r12_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o & cancel_o) == 2'b00);

  for (genvar c = 0; c < 2; c++) begin : g_st
    a_r6_active_no_host: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(evt_run[c]) && !$past(evt_halt[c])) |-> stat[c][0] == $past(stat[c][0]));

    a_r7_run_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(evt_run[c])) |-> stat[c][0]);
  end
endmodule

bind idebm_regfile idebm_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .irq_req   (irq_req),
  .irq_o     (irq_o),
  .blk       (mode_q[5:4]),
  .start_o   (start_o),
  .cancel_o  (cancel_o),
  .evt_run   (evt_run),
  .evt_halt  (evt_halt),
  .stat      (stat_q)
);

// File: tb/idebm_regfile_test.sv
module idebm_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [3:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq_req, evt_run, evt_halt, evt_err, evt_irq;
  logic [1:0]  start_o, cancel_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idebm_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_req(irq_req), .evt_run(evt_run), .evt_halt(evt_halt),
    .evt_err(evt_err), .evt_irq(evt_irq),
    .start_o(start_o), .cancel_o(cancel_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (3) step();
    check("R1 cancel in reset", {30'b0, cancel_o}, 32'h3);
    check("R1 start in reset", {30'b0, start_o}, 32'h0);
    rst_n = 1'b1;
    step();
    check("R1 cancel after reset", {30'b0, cancel_o}, 32'h0);
    check("R11 ready", {31'b0, req_ready}, 32'h1);
    bus_read(4'd0, 2'd2, d);   check("R1 ch0 head", d, 32'h0);
    bus_read(4'd12, 2'd2, d);  check("R1 ch1 desc", d, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_map_timing();
    logic [31:0] d;
    bus_write(4'd3, 2'd0, 32'hA5);
    bus_write(4'd11, 2'd0, 32'h3C);
    bus_read(4'd0, 2'd2, d);  check("R2 ch0 word0", d, 32'hA500_0000);
    bus_read(4'd11, 2'd0, d); check("R9 ch1 timing", d, 32'h3C);
    bus_read(4'd3, 2'd0, d);  check("R9 ch0 timing kept", d, 32'hA5);
  endtask

  task automatic t_desc();
    logic [31:0] d;
    bus_write(4'd4, 2'd2, 32'h1234_5678);
    bus_read(4'd5, 2'd0, d);  check("R10 byte read", d, 32'h56);
    bus_write(4'd6, 2'd1, 32'h0000_BEEF);
    bus_read(4'd4, 2'd2, d);  check("R10 half write", d, 32'hBEEF_5678);
    bus_read(4'd6, 2'd1, d);  check("R11 half upper lanes zero", d, 32'h0000_BEEF);
    bus_write(4'd12, 2'd3, 32'hCAFE_F00D);
    bus_write(4'd15, 2'd0, 32'h11);
    bus_read(4'd12, 2'd2, d); check("R10 ch1 byte write", d, 32'h11FE_F00D);
    bus_read(4'd4, 2'd2, d);  check("R2 ch0 desc isolated", d, 32'hBEEF_5678);
  endtask

  task automatic t_window();
    logic [31:0] d;
    bus_read(4'd14, 2'd2, d); check("R11 past-window lanes", d, 32'hFFFF_11FE);
    bus_write(4'd14, 2'd2, 32'hAABB_CCDD);
    bus_read(4'd12, 2'd2, d); check("R11 past-window write dropped", d, 32'hCCDD_F00D);
    bus_read(4'd0, 2'd2, d);  check("R11 no wrap to ch0", d, 32'hA500_0000);
  endtask

  task automatic t_mode_irq();
    logic [31:0] d;
    irq_req = 2'b01; step();
    check("R5 ch0 raw", {31'b0, irq_o}, 32'h1);
    bus_read(4'd1, 2'd0, d); check("R4 bit2 latch", d, 32'h04);
    bus_read(4'd9, 2'd0, d); check("R3 shared view", d, 32'h04);
    bus_write(4'd9, 2'd0, 32'hFF);
    check("R5 both blocked", {31'b0, irq_o}, 32'h0);
    bus_read(4'd1, 2'd0, d); check("R3 only block bits", d, 32'h34);
    irq_req = 2'b10; step();
    bus_read(4'd1, 2'd0, d); check("R4 bit3 latch", d, 32'h38);
    check("R5 ch1 blocked", {31'b0, irq_o}, 32'h0);
    bus_write(4'd1, 2'd0, 32'h10);
    check("R5 ch1 unblocked", {31'b0, irq_o}, 32'h1);
    irq_req = 2'b01; step();
    check("R5 ch0 blocked", {31'b0, irq_o}, 32'h0);
    bus_write(4'd1, 2'd0, 32'h20);
    check("R5 ch0 passes", {31'b0, irq_o}, 32'h1);
    irq_req = 2'b11; bus_write(4'd1, 2'd0, 32'h30);
    check("R5 all masked", {31'b0, irq_o}, 32'h0);
    irq_req = 2'b00; bus_write(4'd1, 2'd0, 32'h00);
    check("R5 idle", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    evt_err = 2'b01; evt_irq = 2'b01; step();
    evt_err = 2'b00; evt_irq = 2'b00;
    bus_read(4'd2, 2'd0, d); check("R7 err/irq set", d, 32'h06);
    evt_run = 2'b01; step(); evt_run = 2'b00;
    bus_read(4'd2, 2'd0, d); check("R7 active set", d, 32'h07);
    bus_write(4'd2, 2'd0, 32'hFF);
    bus_read(4'd2, 2'd0, d); check("R6 w1c and rw", d, 32'h61);
    bus_write(4'd2, 2'd0, 32'h00);
    bus_read(4'd2, 2'd0, d); check("R6 active unaffected", d, 32'h01);
    evt_halt = 2'b01; step(); evt_halt = 2'b00;
    bus_read(4'd2, 2'd0, d); check("R7 halt clears", d, 32'h00);
    evt_run = 2'b10; evt_halt = 2'b10; step(); evt_run = 2'b00; evt_halt = 2'b00;
    evt_err = 2'b10; bus_write(4'd10, 2'd0, 32'h02); evt_err = 2'b00;
    bus_read(4'd10, 2'd0, d); check("R7 set beats clear", d, 32'h03);
    bus_read(4'd2, 2'd0, d);  check("R2 ch0 status isolated", d, 32'h00);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    bus_write(4'd0, 2'd0, 32'h09);
    check("R8 start pulse", {30'b0, start_o}, 32'h1);
    check("R8 no cancel", {30'b0, cancel_o}, 32'h0);
    step();
    check("R8 start one cycle", {30'b0, start_o}, 32'h0);
    bus_read(4'd0, 2'd0, d); check("R8 cmd readback", d, 32'h09);
    bus_write(4'd8, 2'd0, 32'hFE);
    check("R8 cancel pulse", {30'b0, cancel_o}, 32'h2);
    check("R12 exclusive", {30'b0, start_o}, 32'h0);
    step();
    check("R8 cancel one cycle", {30'b0, cancel_o}, 32'h0);
    bus_read(4'd8, 2'd0, d); check("R8 cmd bits masked", d, 32'h08);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; irq_req = '0; evt_run = '0;
    evt_halt = '0; evt_err = '0; evt_irq = '0;
    @(negedge clk);
    t_reset();
    t_map_timing();
    t_desc();
    t_window();
    t_mode_irq();
    t_status();
    t_cmd();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule